// File: doc/BRIEF.md
# SMRAM Visibility and TSEG Controller

This block holds the two configuration bytes that govern where system management RAM can be seen, and turns them into enables for each view of that memory. One byte is the main control byte: an open bit, a sticky lock bit and a global enable. The other is the extended control byte: a high-alias select, a TSEG enable and a two-bit TSEG size code. Configuration writes are merged through per-byte write masks. Setting the lock bit moves a two-state lock machine from `LK_UNLOCKED` to `LK_LOCKED` (transition LOCK_WRITE). In `LK_LOCKED` the open bit stays cleared and both write masks shrink to zero. Only reset (transition RESET) returns the machine to `LK_UNLOCKED`.

From the stored bytes the block derives these enables: the legacy view for normal cycles, an open alias at the high address, and the low and high aliases that only SMM cycles can see. It also computes a TSEG region that ends at the below-4G memory size. The block decodes one access (start address, SMM flag, byte count) against these regions. A normal-cycle access that lands in TSEG hits a blackhole that reads all ones. An SMM access to the same range hits the SMM window. Accesses to the high alias are steered according to the cycle type.

Top module: `smram_ctrl`

## Requirements
- R1: After reset the control byte reads 0x02, the extended byte reads 0x00, `locked` is 0, the legacy view is on, all other views are off, the TSEG size is 0 and the TSEG base equals `low_mem_size`.
- R2: A write with `cfg_wr_sel`=0 targets the control byte and one with `cfg_wr_sel`=1 targets the extended byte. Each is stored as (old & ~mask) | (data & mask) one clock after the write. Before lock the control mask is 0x58 (bit 6 open, bit 4 lock, bit 3 global enable; bits 2:0 keep 010, bits 7 and 5 read 0). Before lock the extended mask is 0x87 (bit 7 high select, bits 2:1 size code, bit 0 TSEG enable).
- R3: A control write whose merged value has bit 4 set stores the open bit as 0 in that same write and sets `locked`. From then on, writes to either byte leave both unchanged until reset. Reset clears the lock.
- R4: With the open bit set, the legacy view and the open high alias both equal the high-select bit.
- R5: With the open bit clear, the legacy view is on and the open high alias is off.
- R6: With the global enable set, the SMM low alias is on when high select is 0 and the SMM high alias is on when it is 1. With the global enable clear, both are off.
- R7: The TSEG size is non-zero only when the TSEG enable and the global enable are both set. In that case size code 0 gives 1 MiB, code 1 gives 2 MiB, code 2 gives 8 MiB and code 3 gives `EXT_TSEG_MB` MiB.
- R8: `tseg_base` equals `low_mem_size` minus `tseg_size`, and `tseg_on` is set exactly when the size is non-zero.
- R9: An access of 1 to 4 bytes whose start address lies in [tseg_base, low_mem_size) while `tseg_on` is set does one of two things. If it is a non-SMM access it raises `hole_hit` with `hole_rdata` all ones. If it is an SMM access it raises `window_hit` and leaves `hole_hit` at 0. A byte count of 0 or above 4 hits nothing.
- R10: The high alias spans 128 KiB from 0xFEDA0000. An access there raises `high_alias_hit` when it is a non-SMM access and the open high alias is on, or when it is an SMM access and the SMM high alias is on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_sel | input | 1 | 0 selects control byte, 1 selects extended byte |
| cfg_wr_data | input | 8 | Write data |
| low_mem_size | input | ADDR_W | Size of memory below 4G, in bytes |
| acc_addr | input | ADDR_W | Start address of the decoded access |
| acc_smm | input | 1 | Access is an SMM cycle |
| acc_len | input | LEN_W | Access byte count |
| ctl_q | output | 8 | Stored control byte |
| ext_q | output | 8 | Stored extended control byte |
| locked | output | 1 | Lock machine is in LK_LOCKED |
| legacy_view_en | output | 1 | Legacy area visible to normal cycles |
| open_high_en | output | 1 | High alias open to normal cycles |
| smm_low_en | output | 1 | Low alias for SMM cycles |
| smm_high_en | output | 1 | High alias for SMM cycles |
| tseg_on | output | 1 | TSEG blackhole and window enabled |
| tseg_base | output | ADDR_W | TSEG start address |
| tseg_size | output | ADDR_W | TSEG size in bytes |
| hole_hit | output | 1 | Non-SMM access hits the TSEG blackhole |
| hole_rdata | output | DATA_W | Blackhole read data |
| window_hit | output | 1 | SMM access hits the TSEG window |
| high_alias_hit | output | 1 | Access hits an enabled high alias |

## Verification
Both bytes are swept over every value that leaves the lock bit clear, and every view enable and TSEG result is compared after each write. This exposes a design that swaps the two aliases, ignores the global enable when gating TSEG, or misdecodes one size code. The lock cases target a design that clears the open bit a cycle late, lets the lock be cleared by a write, or keeps the extended byte writable after locking. The access checks probe the region edges, including the address one below the TSEG base, the address at the memory top, the last byte of the high alias, and byte counts of 0 and 5. An off-by-one range or a missing length check would show up as a stray or missing hit.

// File: rtl/smram_pkg.sv
package smram_pkg;

    localparam int CTL_W = 8;

    // control byte fields
    localparam int CTL_OPEN_BIT   = 6;
    localparam int CTL_LOCK_BIT   = 4;
    localparam int CTL_GLOBAL_BIT = 3;

    // extended byte fields
    localparam int EXT_HIGH_BIT   = 7;
    localparam int EXT_CODE_LSB   = 1;
    localparam int EXT_CODE_W     = 2;
    localparam int EXT_TSEG_BIT   = 0;

    localparam logic [CTL_W-1:0] CTL_RESET       = 8'h02;
    localparam logic [CTL_W-1:0] EXT_RESET       = 8'h00;
    localparam logic [CTL_W-1:0] CTL_WMASK_FULL  = 8'h58;
    localparam logic [CTL_W-1:0] EXT_WMASK_FULL  = 8'h87;
    localparam logic [CTL_W-1:0] CTL_WMASK_LOCK  = 8'h00;
    localparam logic [CTL_W-1:0] EXT_WMASK_LOCK  = 8'h00;

    localparam logic SEL_CTL = 1'b0;
    localparam logic SEL_EXT = 1'b1;

    typedef enum logic {
        LK_UNLOCKED = 1'b0,
        LK_LOCKED   = 1'b1
    } lock_state_e;

    typedef enum logic [EXT_CODE_W-1:0] {
        TS_1M  = 2'd0,
        TS_2M  = 2'd1,
        TS_8M  = 2'd2,
        TS_EXT = 2'd3
    } tseg_code_e;

    typedef struct packed {
        logic legacy;
        logic open_high;
        logic smm_low;
        logic smm_high;
    } view_en_t;

endpackage

// File: rtl/smram_regs.sv
module smram_regs
    import smram_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [CTL_W-1:0] wr_data,
    output logic [CTL_W-1:0] ctl_q,
    output logic [CTL_W-1:0] ext_q,
    output logic             locked
);

    lock_state_e      state_q;
    lock_state_e      state_d;
    logic [CTL_W-1:0] ctl_mask;
    logic [CTL_W-1:0] ext_mask;
    logic [CTL_W-1:0] ctl_merged;
    logic [CTL_W-1:0] ext_merged;
    logic             ctl_wr;
    logic             ext_wr;

    assign ctl_wr = wr_en && (wr_sel == SEL_CTL);
    assign ext_wr = wr_en && (wr_sel == SEL_EXT);

    // Outputs of the lock machine: the write masks in force.
    always_comb begin : p_lock_outputs
        unique case (state_q)
            LK_UNLOCKED: begin
                ctl_mask = CTL_WMASK_FULL;
                ext_mask = EXT_WMASK_FULL;
            end
            LK_LOCKED: begin
                ctl_mask = CTL_WMASK_LOCK;
                ext_mask = EXT_WMASK_LOCK;
            end
            default: begin
                ctl_mask = CTL_WMASK_LOCK;
                ext_mask = EXT_WMASK_LOCK;
            end
        endcase
    end

    // Masked merge; a set lock bit drops the open bit in the same write.
    always_comb begin : p_merge
        ctl_merged = (ctl_q & ~ctl_mask) | (wr_data & ctl_mask);
        ext_merged = (ext_q & ~ext_mask) | (wr_data & ext_mask);
        if (ctl_merged[CTL_LOCK_BIT]) begin
            ctl_merged[CTL_OPEN_BIT] = 1'b0;
        end
    end

    // Next state: LOCK_WRITE moves UNLOCKED to LOCKED; only reset leaves LOCKED.
    always_comb begin : p_next_state
        state_d = state_q;
        unique case (state_q)
            LK_UNLOCKED: begin
                if (ctl_wr && ctl_merged[CTL_LOCK_BIT]) begin
                    state_d = LK_LOCKED;
                end
            end
            LK_LOCKED: state_d = LK_LOCKED;
            default:   state_d = LK_UNLOCKED;
        endcase
    end

    always_ff @(posedge clk) begin : p_state_reg
        if (!rst_n) begin
            state_q <= LK_UNLOCKED;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin : p_data_regs
        if (!rst_n) begin
            ctl_q <= CTL_RESET;
            ext_q <= EXT_RESET;
        end else begin
            if (ctl_wr) begin
                ctl_q <= ctl_merged;
            end
            if (ext_wr) begin
                ext_q <= ext_merged;
            end
        end
    end

    assign locked = (state_q == LK_LOCKED);

endmodule

// File: rtl/smram_views.sv
module smram_views
    import smram_pkg::*;
(
    input  logic     open_bit,
    input  logic     global_bit,
    input  logic     high_bit,
    output view_en_t views
);

    always_comb begin : p_views
        if (open_bit) begin
            views.legacy    = high_bit;
            views.open_high = high_bit;
        end else begin
            views.legacy    = 1'b1;
            views.open_high = 1'b0;
        end
        views.smm_low  = global_bit && !high_bit;
        views.smm_high = global_bit && high_bit;
    end

endmodule

// File: rtl/smram_tseg.sv
module smram_tseg
    import smram_pkg::*;
#(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned EXT_TSEG_MB = 16
) (
    input  logic                  tseg_bit,
    input  logic                  global_bit,
    input  logic [EXT_CODE_W-1:0] size_code,
    input  logic [ADDR_W-1:0]     low_mem,
    output logic [ADDR_W-1:0]     size,
    output logic [ADDR_W-1:0]     base,
    output logic                  on
);

    localparam int unsigned MIB_SHIFT = 20;
    localparam logic [ADDR_W-1:0] SZ_1M  = ADDR_W'(1)  << MIB_SHIFT;
    localparam logic [ADDR_W-1:0] SZ_2M  = ADDR_W'(2)  << MIB_SHIFT;
    localparam logic [ADDR_W-1:0] SZ_8M  = ADDR_W'(8)  << MIB_SHIFT;
    localparam logic [ADDR_W-1:0] SZ_EXT = ADDR_W'(EXT_TSEG_MB) << MIB_SHIFT;

    always_comb begin : p_size
        size = '0;
        if (tseg_bit && global_bit) begin
            unique case (tseg_code_e'(size_code))
                TS_1M:   size = SZ_1M;
                TS_2M:   size = SZ_2M;
                TS_8M:   size = SZ_8M;
                TS_EXT:  size = SZ_EXT;
                default: size = '0;
            endcase
        end
    end

    assign base = low_mem - size;
    assign on   = |size;

endmodule

// File: rtl/smram_access.sv
module smram_access #(
    parameter int unsigned ADDR_W        = 32,
    parameter int unsigned MAX_ACC_BYTES = 4,
    parameter int unsigned LEN_W         = 3,
    parameter int unsigned DATA_W        = 32,
    parameter logic [ADDR_W-1:0] HIGH_BASE = ADDR_W'(32'hFEDA_0000),
    parameter logic [ADDR_W-1:0] HIGH_SPAN = ADDR_W'(32'h0002_0000)
) (
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_smm,
    input  logic [LEN_W-1:0]  acc_len,
    input  logic [ADDR_W-1:0] low_mem,
    input  logic [ADDR_W-1:0] tseg_base,
    input  logic              tseg_on,
    input  logic              open_high_en,
    input  logic              smm_high_en,
    output logic              hole_hit,
    output logic [DATA_W-1:0] hole_rdata,
    output logic              window_hit,
    output logic              high_alias_hit
);

    localparam logic [ADDR_W-1:0] HIGH_END = HIGH_BASE + HIGH_SPAN;

    logic len_ok;
    logic in_tseg;
    logic in_high;

    assign len_ok  = (acc_len != '0) && (acc_len <= LEN_W'(MAX_ACC_BYTES));
    assign in_tseg = tseg_on && (acc_addr >= tseg_base) && (acc_addr < low_mem);
    assign in_high = (acc_addr >= HIGH_BASE) && (acc_addr < HIGH_END);

    assign hole_hit   = len_ok && in_tseg && !acc_smm;
    assign window_hit = len_ok && in_tseg && acc_smm;
    assign hole_rdata = hole_hit ? {DATA_W{1'b1}} : '0;

    assign high_alias_hit = len_ok && in_high && (acc_smm ? smm_high_en : open_high_en);

endmodule

// File: rtl/smram_ctrl.sv
module smram_ctrl
    import smram_pkg::*;
#(
    parameter int unsigned ADDR_W        = 32,
    parameter int unsigned EXT_TSEG_MB   = 16,
    parameter int unsigned MAX_ACC_BYTES = 4,
    parameter logic [ADDR_W-1:0] HIGH_ALIAS_BASE = ADDR_W'(32'hFEDA_0000),
    parameter logic [ADDR_W-1:0] HIGH_ALIAS_SPAN = ADDR_W'(32'h0002_0000),
    localparam int unsigned LEN_W  = $clog2(MAX_ACC_BYTES + 1),
    localparam int unsigned DATA_W = 8 * MAX_ACC_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic              cfg_wr_sel,
    input  logic [7:0]        cfg_wr_data,
    input  logic [ADDR_W-1:0] low_mem_size,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_smm,
    input  logic [LEN_W-1:0]  acc_len,
    output logic [7:0]        ctl_q,
    output logic [7:0]        ext_q,
    output logic              locked,
    output logic              legacy_view_en,
    output logic              open_high_en,
    output logic              smm_low_en,
    output logic              smm_high_en,
    output logic              tseg_on,
    output logic [ADDR_W-1:0] tseg_base,
    output logic [ADDR_W-1:0] tseg_size,
    output logic              hole_hit,
    output logic [DATA_W-1:0] hole_rdata,
    output logic              window_hit,
    output logic              high_alias_hit
);

    view_en_t views;

    smram_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_sel  (cfg_wr_sel),
        .wr_data (cfg_wr_data),
        .ctl_q   (ctl_q),
        .ext_q   (ext_q),
        .locked  (locked)
    );

    smram_views u_views (
        .open_bit   (ctl_q[CTL_OPEN_BIT]),
        .global_bit (ctl_q[CTL_GLOBAL_BIT]),
        .high_bit   (ext_q[EXT_HIGH_BIT]),
        .views      (views)
    );

    assign legacy_view_en = views.legacy;
    assign open_high_en   = views.open_high;
    assign smm_low_en     = views.smm_low;
    assign smm_high_en    = views.smm_high;

    smram_tseg #(
        .ADDR_W      (ADDR_W),
        .EXT_TSEG_MB (EXT_TSEG_MB)
    ) u_tseg (
        .tseg_bit   (ext_q[EXT_TSEG_BIT]),
        .global_bit (ctl_q[CTL_GLOBAL_BIT]),
        .size_code  (ext_q[EXT_CODE_LSB +: EXT_CODE_W]),
        .low_mem    (low_mem_size),
        .size       (tseg_size),
        .base       (tseg_base),
        .on         (tseg_on)
    );

    smram_access #(
        .ADDR_W        (ADDR_W),
        .MAX_ACC_BYTES (MAX_ACC_BYTES),
        .LEN_W         (LEN_W),
        .DATA_W        (DATA_W),
        .HIGH_BASE     (HIGH_ALIAS_BASE),
        .HIGH_SPAN     (HIGH_ALIAS_SPAN)
    ) u_access (
        .acc_addr       (acc_addr),
        .acc_smm        (acc_smm),
        .acc_len        (acc_len),
        .low_mem        (low_mem_size),
        .tseg_base      (tseg_base),
        .tseg_on        (tseg_on),
        .open_high_en   (views.open_high),
        .smm_high_en    (views.smm_high),
        .hole_hit       (hole_hit),
        .hole_rdata     (hole_rdata),
        .window_hit     (window_hit),
        .high_alias_hit (high_alias_hit)
    );

endmodule

// File: rtl/smram_ctrl_chk.sv
module smram_ctrl_chk #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [7:0]        ctl_q,
    input logic [7:0]        ext_q,
    input logic              locked,
    input logic              legacy_view_en,
    input logic              open_high_en,
    input logic              smm_low_en,
    input logic              smm_high_en,
    input logic              tseg_on,
    input logic [ADDR_W-1:0] tseg_base,
    input logic [ADDR_W-1:0] tseg_size,
    input logic [ADDR_W-1:0] low_mem_size,
    input logic              hole_hit,
    input logic [DATA_W-1:0] hole_rdata,
    input logic              window_hit
);

    assert_open_cleared_R3: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> !ctl_q[6]);

    assert_lock_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked);

    assert_regs_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> ($stable(ctl_q) && $stable(ext_q)));

    assert_closed_view_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_q[6] |-> (legacy_view_en && !open_high_en));

    assert_alias_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(smm_low_en && smm_high_en));

    assert_tseg_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tseg_on |-> (ext_q[0] && ctl_q[3]));

    assert_base_sum_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tseg_base + tseg_size) == low_mem_size);

    assert_hole_vs_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(hole_hit && window_hit));

    assert_hole_ones_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hole_hit |-> (hole_rdata == {DATA_W{1'b1}}));

endmodule

bind smram_ctrl smram_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .ctl_q          (ctl_q),
    .ext_q          (ext_q),
    .locked         (locked),
    .legacy_view_en (legacy_view_en),
    .open_high_en   (open_high_en),
    .smm_low_en     (smm_low_en),
    .smm_high_en    (smm_high_en),
    .tseg_on        (tseg_on),
    .tseg_base      (tseg_base),
    .tseg_size      (tseg_size),
    .low_mem_size   (low_mem_size),
    .hole_hit       (hole_hit),
    .hole_rdata     (hole_rdata),
    .window_hit     (window_hit)
);

// File: tb/test_smram_ctrl.sv
`timescale 1ns/1ps
module test_smram_ctrl;

    localparam int unsigned EXT_MB = 16;
    localparam int unsigned WATCHDOG_CYCLES = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic        cfg_wr_sel = 1'b0;
    logic [7:0]  cfg_wr_data = 8'h00;
    logic [31:0] low_mem_size = 32'h8000_0000;
    logic [31:0] acc_addr = 32'h0;
    logic        acc_smm = 1'b0;
    logic [2:0]  acc_len = 3'd0;
    logic [7:0]  ctl_q, ext_q;
    logic        locked, legacy_view_en, open_high_en, smm_low_en, smm_high_en;
    logic        tseg_on, hole_hit, window_hit, high_alias_hit;
    logic [31:0] tseg_base, tseg_size, hole_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    smram_ctrl #(.EXT_TSEG_MB(EXT_MB)) i_smram_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel),
        .cfg_wr_data(cfg_wr_data), .low_mem_size(low_mem_size), .acc_addr(acc_addr),
        .acc_smm(acc_smm), .acc_len(acc_len), .ctl_q(ctl_q), .ext_q(ext_q),
        .locked(locked), .legacy_view_en(legacy_view_en), .open_high_en(open_high_en),
        .smm_low_en(smm_low_en), .smm_high_en(smm_high_en), .tseg_on(tseg_on),
        .tseg_base(tseg_base), .tseg_size(tseg_size), .hole_hit(hole_hit),
        .hole_rdata(hole_rdata), .window_hit(window_hit), .high_alias_hit(high_alias_hit)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wr_data = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic probe(input logic [31:0] a, input logic smm, input logic [2:0] len);
        acc_addr = a; acc_smm = smm; acc_len = len;
        #0.5;
    endtask

    function automatic logic [31:0] exp_size(input logic [7:0] c, input logic [7:0] e);
        if (!(c[3] && e[0])) return 32'h0;
        case (e[2:1])
            2'd0: return 32'd1 << 20;
            2'd1: return 32'd2 << 20;
            2'd2: return 32'd8 << 20;
            default: return EXT_MB << 20;
        endcase
    endfunction

    task automatic check_all(input logic [7:0] c, input logic [7:0] e, input string where);
        logic [3:0] ev;
        logic [31:0] sz;
        ev[3] = c[6] ? e[7] : 1'b1;
        ev[2] = c[6] ? e[7] : 1'b0;
        ev[1] = c[3] && !e[7];
        ev[0] = c[3] && e[7];
        sz = exp_size(c, e);
        chk({"R2 ctl ", where}, {24'h0, ctl_q}, {24'h0, c});
        chk({"R2 ext ", where}, {24'h0, ext_q}, {24'h0, e});
        if (c[6]) chk({"R4 views ", where}, {28'h0, legacy_view_en, open_high_en, smm_low_en, smm_high_en}, {28'h0, ev});
        else      chk({"R5 views ", where}, {28'h0, legacy_view_en, open_high_en, smm_low_en, smm_high_en}, {28'h0, ev});
        chk({"R6 smm aliases ", where}, {30'h0, smm_low_en, smm_high_en}, {30'h0, ev[1:0]});
        chk({"R7 size ", where}, tseg_size, sz);
        chk({"R8 base ", where}, tseg_base, low_mem_size - sz);
        chk({"R8 on ", where}, {31'h0, tseg_on}, {31'h0, sz != 0});
    endtask

    initial begin : watchdog
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : main
        do_reset();
        // R1 reset state
        chk("R1 ctl", {24'h0, ctl_q}, 32'h02);
        chk("R1 ext", {24'h0, ext_q}, 32'h00);
        chk("R1 locked", {31'h0, locked}, 32'h0);
        chk("R1 views", {28'h0, legacy_view_en, open_high_en, smm_low_en, smm_high_en}, 32'h8);
        chk("R1 size", tseg_size, 32'h0);
        chk("R1 base", tseg_base, low_mem_size);

        // R2/R4-R8 sweep: all control values without lock, all extended values
        for (int s = 0; s < 128; s++) begin
            logic [7:0] cd, cexp;
            cd = {s[6:4], 1'b0, s[3:0]};
            wr(1'b0, cd);
            cexp = (cd & 8'h58) | 8'h02;
            chk("R2 ctl write", {24'h0, ctl_q}, {24'h0, cexp});
            for (int e = 0; e < 256; e++) begin
                logic [7:0] ed;
                ed = 8'(e);
                wr(1'b1, ed);
                check_all(cexp, ed & 8'h87, "sweep");
            end
        end

        // R7 extended code with another memory size
        low_mem_size = 32'h4000_0000;
        wr(1'b0, 8'h08); wr(1'b1, 8'h07);
        chk("R7 ext size", tseg_size, 32'h0100_0000);
        chk("R8 ext base", tseg_base, 32'h3F00_0000);

        // R9 blackhole / window, 8 MiB at top of 2 GiB
        low_mem_size = 32'h8000_0000;
        wr(1'b1, 8'h05);
        probe(32'h7F80_0000, 1'b0, 3'd4);
        chk("R9 hole at base", {31'h0, hole_hit}, 32'h1);
        chk("R9 hole rdata", hole_rdata, 32'hFFFF_FFFF);
        probe(32'h7F7F_FFFF, 1'b0, 3'd1);
        chk("R9 below base", {31'h0, hole_hit}, 32'h0);
        probe(32'h7FFF_FFFF, 1'b0, 3'd1);
        chk("R9 last byte", {31'h0, hole_hit}, 32'h1);
        probe(32'h8000_0000, 1'b0, 3'd1);
        chk("R9 at top", {31'h0, hole_hit}, 32'h0);
        probe(32'h7F90_0000, 1'b0, 3'd0);
        chk("R9 len0", {31'h0, hole_hit}, 32'h0);
        probe(32'h7F90_0000, 1'b0, 3'd5);
        chk("R9 len5", {31'h0, hole_hit}, 32'h0);
        probe(32'h7F90_0000, 1'b1, 3'd2);
        chk("R9 smm window", {30'h0, window_hit, hole_hit}, 32'h2);
        chk("R9 smm rdata", hole_rdata, 32'h0);

        // R10 high alias
        wr(1'b0, 8'h48); wr(1'b1, 8'h80);
        probe(32'hFEDA_0000, 1'b0, 3'd4);
        chk("R10 open normal", {31'h0, high_alias_hit}, 32'h1);
        probe(32'hFEDB_FFFF, 1'b1, 3'd1);
        chk("R10 smm last", {31'h0, high_alias_hit}, 32'h1);
        probe(32'hFEDC_0000, 1'b1, 3'd1);
        chk("R10 past end", {31'h0, high_alias_hit}, 32'h0);
        wr(1'b0, 8'h40);
        probe(32'hFEDA_0000, 1'b1, 3'd1);
        chk("R10 smm global off", {31'h0, high_alias_hit}, 32'h0);
        wr(1'b1, 8'h00);
        probe(32'hFEDA_0000, 1'b0, 3'd1);
        chk("R10 normal closed", {31'h0, high_alias_hit}, 32'h0);

        // R3 lock with open in same write
        do_reset();
        wr(1'b1, 8'h81);
        wr(1'b0, 8'h58);
        chk("R3 lock same write", {24'h0, ctl_q}, 32'h1A);
        chk("R3 locked", {31'h0, locked}, 32'h1);
        wr(1'b0, 8'h48);
        chk("R3 ctl frozen", {24'h0, ctl_q}, 32'h1A);
        wr(1'b1, 8'h06);
        chk("R3 ext frozen", {24'h0, ext_q}, 32'h81);
        chk("R3 views after lock", {28'h0, legacy_view_en, open_high_en, smm_low_en, smm_high_en}, 32'h9);
        do_reset();
        chk("R3 reset unlock", {31'h0, locked}, 32'h0);
        chk("R3 reset ctl", {24'h0, ctl_q}, 32'h02);
        // R3 lock after open was set earlier
        wr(1'b0, 8'h40);
        chk("R3 open set", {24'h0, ctl_q}, 32'h42);
        wr(1'b0, 8'h50);
        chk("R3 open dropped", {24'h0, ctl_q}, 32'h12);
        wr(1'b0, 8'h00);
        chk("R3 lock sticky", {24'h0, ctl_q}, 32'h12);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule